// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

This block is an N-bit twisted-ring counter (N defaults to 4). On every clock the stored word moves one place toward its most significant bit, and the inverted top bit enters at the bottom. The counter therefore walks through 2N distinct words and then repeats. Each of those words drives one bit of a one-hot phase bus. Each phase bit is the AND of two neighbouring register bits, one true and one inverted. The phase bits come straight from flip-flops through a single gate level, so they do not glitch. This makes the bus suitable as a set of sequencing enables for control logic.

Only 2N of the 2^N possible words are part of the cycle. The other 2^N − 2N words can appear after an upset or at power-up. The next-state logic has one extra two-input term for this case. When the top bit and the bottom bit are both 0, the next word is forced to 00…01. Every stray word then joins the cycle within N clocks, with no reset needed. A synchronous reset and a seed load are still provided. The reset aligns the counter with other logic. The seed load places the register at any chosen word, including a stray one.

Top module: `twisted_ring_ctr`

## Requirements
- R1: While `rst_i` is high at a clock edge, the next state is all zeros. After the reset is released, `phase_o` bit 0 is the only phase bit set.
- R2: When `seed_load_i` is high and `rst_i` is low at a clock edge, the next state equals `seed_val_i`. When both are high, the reset wins.
- R3: With both controls low, a word in the cycle advances by a left shift with the inverted MSB entering bit 0. For N=4 the order is 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, and then 0000 again.
- R4: In cycle word number k, `phase_o` equals 1 << k and no other phase bit is set. Word k is numbered as follows:
  - For k ≤ N, word k has its k low bits set.
  - For k > N, word k has its k−N low bits clear and all other bits set.
- R5: With both controls low, a word whose MSB and LSB are both 0 is followed by 00…01.
- R6: Starting from any of the 2^N words, the counter holds a cycle word within N clocks, with the controls held low.
- R7: Once the state is a cycle word, it stays in the cycle for as long as the controls stay low, and `phase_o` rotates up by one position per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high, clears the state |
| seed_load_i | input | 1 | Loads `seed_val_i` into the state at the next edge |
| seed_val_i | input | N | Word to load |
| state_o | output | N | Raw register contents |
| phase_o | output | 2N | Decoded phase bus, one-hot in cycle words |

## Verification
A stray word in the register shows up at once on the ports. `state_o` no longer matches any cycle word, and `phase_o` shows either no bit or several bits set. A single wrong shift or repair decision is visible on the next clock. In that case `state_o` differs from the model's successor word, and the phase bus fails to move by exactly one position. Every stray word must disappear within N clocks of its load. A repair term that is missing or wrong therefore either leaves the register in a false loop or changes the route it takes back to the cycle.

// File: rtl/jc_pkg.sv
package jc_pkg;

    // Choice of next-state source, highest priority first in the selector.
    typedef enum logic [1:0] {
        ACT_SHIFT  = 2'd0,
        ACT_REPAIR = 2'd1,
        ACT_SEED   = 2'd2,
        ACT_CLEAR  = 2'd3
    } jc_act_e;

endpackage

// File: rtl/jc_action.sv
module jc_action
    import jc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         rst_i,
    input  logic         seed_load_i,
    input  logic [N-1:0] cur_i,
    output jc_act_e      act_o
);

    // Both end bits clear marks a word that must be repaired.
    // The all-zero cycle word also matches, and repairing it gives its normal successor.
    logic ends_low;

    assign ends_low = ~(cur_i[N-1] | cur_i[0]);

    always_comb begin
        if (rst_i) begin
            act_o = ACT_CLEAR;
        end else if (seed_load_i) begin
            act_o = ACT_SEED;
        end else if (ends_low) begin
            act_o = ACT_REPAIR;
        end else begin
            act_o = ACT_SHIFT;
        end
    end

endmodule

// File: rtl/jc_phase_dec.sv
module jc_phase_dec #(
    parameter int N = 4,
    localparam int P = 2 * N
) (
    input  logic [N-1:0] cur_i,
    output logic [P-1:0] phase_o
);

    // Each phase bit uses the single pair of neighbouring bits that marks its word.
    for (genvar k = 0; k < P; k++) begin : g_term
        if (k == 0) begin : g_zero
            assign phase_o[k] = ~cur_i[N-1] & ~cur_i[0];
        end else if (k < N) begin : g_fill
            assign phase_o[k] = cur_i[k-1] & ~cur_i[k];
        end else if (k == N) begin : g_full
            assign phase_o[k] = cur_i[N-1] & cur_i[0];
        end else begin : g_drain
            assign phase_o[k] = ~cur_i[k-N-1] & cur_i[k-N];
        end
    end

endmodule

// File: rtl/twisted_ring_ctr.sv
module twisted_ring_ctr
    import jc_pkg::*;
#(
    parameter int N = 4,          // register width, at least 2
    localparam int P = 2 * N      // number of cycle words
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         seed_load_i,
    input  logic [N-1:0] seed_val_i,
    output logic [N-1:0] state_o,
    output logic [P-1:0] phase_o
);

    typedef struct packed {
        logic [N-1:0] ring;
    } ring_t;

    localparam logic [N-1:0] RING_ONE = {{(N-1){1'b0}}, 1'b1};

    ring_t   ring_d, ring_q;
    jc_act_e act;

    jc_action #(.N(N)) u_action (
        .rst_i       (rst_i),
        .seed_load_i (seed_load_i),
        .cur_i       (ring_q.ring),
        .act_o       (act)
    );

    always_comb begin
        ring_d = ring_q;
        unique case (act)
            ACT_CLEAR:  ring_d.ring = '0;
            ACT_SEED:   ring_d.ring = seed_val_i;
            ACT_REPAIR: ring_d.ring = RING_ONE;
            default:    ring_d.ring = {ring_q.ring[N-2:0], ~ring_q.ring[N-1]};
        endcase
    end

    always_ff @(posedge clk_i) begin
        ring_q <= ring_d;
    end

    jc_phase_dec #(.N(N)) u_dec (
        .cur_i   (ring_q.ring),
        .phase_o (phase_o)
    );

    assign state_o = ring_q.ring;

endmodule

// File: rtl/twisted_ring_ctr_chk.sv
module twisted_ring_ctr_chk #(
    parameter int N = 4,
    localparam int P = 2 * N,
    localparam int CW = $clog2(N + 2) + 1
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         seed_load_i,
    input logic [N-1:0] seed_val_i,
    input logic [N-1:0] state_o,
    input logic [P-1:0] phase_o
);

    function automatic logic [N-1:0] cyc_word(input int k);
        logic [N-1:0] w;
        for (int i = 0; i < N; i++) begin
            w[i] = (k <= N) ? (i < k) : !(i < k - N);
        end
        return w;
    endfunction

    logic in_cycle;
    always_comb begin
        in_cycle = 1'b0;
        for (int k = 0; k < P; k++) begin
            if (state_o == cyc_word(k)) in_cycle = 1'b1;
        end
    end

    logic          quiet;
    logic [CW-1:0] stray_cnt;
    assign quiet = ~rst_i & ~seed_load_i;

    always_ff @(posedge clk_i) begin
        if (!quiet) begin
            stray_cnt <= '0;
        end else if (!in_cycle) begin
            if (stray_cnt <= CW'(N)) stray_cnt <= stray_cnt + 1'b1;
        end else begin
            stray_cnt <= '0;
        end
    end

    // R1
    clear_on_reset_chk: assert property (@(posedge clk_i)
        rst_i |=> (state_o == '0));

    // R2
    seed_take_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        seed_load_i |=> (state_o == $past(seed_val_i)));

    // R4
    single_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        in_cycle |-> ($countones(phase_o) == 1));

    // R5
    repair_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_load_i && !state_o[N-1] && !state_o[0]) |=> (state_o == {{(N-1){1'b0}}, 1'b1}));

    // R7
    phase_rotate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!seed_load_i && in_cycle) |=> (phase_o == {$past(phase_o[P-2:0]), $past(phase_o[P-1])}));

    // R6
    converge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        stray_cnt <= CW'(N));

endmodule

bind twisted_ring_ctr twisted_ring_ctr_chk #(.N(N)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .seed_load_i (seed_load_i),
    .seed_val_i  (seed_val_i),
    .state_o     (state_o),
    .phase_o     (phase_o)
);

// File: tb/sim_twisted_ring_ctr.sv
`timescale 1ns/1ps
module sim_twisted_ring_ctr;

    localparam int N = 4;
    localparam int P = 2 * N;
    localparam int MASK = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         seed_load = 1'b0;
    logic [N-1:0] seed_val = '0;
    logic [N-1:0] state;
    logic [P-1:0] phase;

    int checks = 0;
    int errors = 0;
    int model = 0;
    int cyc_q[$];

    always #2.5 clk = ~clk;

    twisted_ring_ctr #(.N(N)) u0 (
        .clk_i       (clk),
        .rst_i       (rst),
        .seed_load_i (seed_load),
        .seed_val_i  (seed_val),
        .state_o     (state),
        .phase_o     (phase)
    );

    function automatic int cyc_idx(input int w);
        for (int i = 0; i < cyc_q.size(); i++) if (cyc_q[i] == w) return i;
        return -1;
    endfunction

    function automatic int ref_next(input int s, input bit r, input bit ld, input int sd);
        int idx;
        if (r) return 0;
        if (ld) return sd & MASK;
        idx = cyc_idx(s);
        if (idx >= 0) return cyc_q[(idx + 1) % P];
        if (((s >> (N - 1)) & 1) == 0 && (s & 1) == 0) return 1;
        return ((s << 1) | (((s >> (N - 1)) & 1) ^ 1)) & MASK;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit ld, input int sd);
        string tag;
        int idx;
        @(negedge clk);
        rst = r;
        seed_load = ld;
        seed_val = sd[N-1:0];
        if (r) tag = "R1";
        else if (ld) tag = "R2";
        else if (cyc_idx(model) >= 0) tag = "R3";
        else tag = "R5";
        @(posedge clk);
        model = ref_next(model, r, ld, sd);
        #1;
        check(int'(state) == model, tag, int'(state), model);
        idx = cyc_idx(model);
        if (idx >= 0) check(phase == P'(1) << idx, "R4", int'(phase), 1 << idx);
    endtask

    initial begin
        for (int k = 0; k < P; k++) begin
            if (k <= N) cyc_q.push_back((1 << k) - 1);
            else cyc_q.push_back(MASK ^ ((1 << (k - N)) - 1));
        end

        // R1: reset state, and reset wins over a seed load (R2)
        step(1, 0, 0);
        check(phase == P'(1), "R1", int'(phase), 1);
        step(1, 1, 5);
        check(int'(state) == 0, "R2", int'(state), 0);

        // R3, R4: run around the cycle three times
        for (int i = 0; i < 3 * P; i++) step(0, 0, 0);

        // R2: a seed load in the middle of the cycle
        step(0, 1, 4'b0111);
        step(0, 0, 0);
        check(int'(state) == 4'b1111, "R3", int'(state), 4'b1111);

        // R6, R7: start from every possible word
        for (int s = 0; s < (1 << N); s++) begin
            int n;
            step(0, 1, s);
            n = 0;
            while (cyc_idx(int'(state)) < 0 && n < N + 3) begin
                step(0, 0, 0);
                n++;
            end
            check(n <= N, "R6", n, N);
            for (int i = 0; i < P + 1; i++) begin
                step(0, 0, 0);
                check(cyc_idx(int'(state)) >= 0, "R7", int'(state), model);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule